// File: doc/BRIEF.md
# Four-Phase Handshake Stage Controller

This block controls one stage of a pipeline whose neighbours talk through four-phase request/acknowledge pairs. On the upstream side it takes a request and returns an acknowledge. On the downstream side it drives a request and receives an acknowledge. A single busy flag covers the whole life of one item. The flag is set when the controller accepts a request and pulses a capture enable to the stage datapath. It stays set while the stage works and while the downstream exchange runs. It clears only when that exchange has fully returned to zero.

Both acknowledge and request inputs from the neighbours may arrive at any time, so they pass through synchroniser flops before use. The processing-done strobe comes from logic in the same clock domain and is used directly. The controller is built so that a partner that withdraws a request or an acknowledge too early cannot leave it stuck in a waiting state.

Top module: `hs_stage_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, up_ack, dn_req and cap_en are all 0.
- R2: A request is not accepted while busy is 1, nor while up_ack is still 1 from the previous item. Such a request leaves cap_en and up_ack unchanged.
- R3: Once idle, a request that goes high at the port is accepted at the third rising clock edge (two synchroniser flops plus one). At that edge up_ack, busy and cap_en all rise.
- R4: cap_en is high for exactly one cycle per acceptance.
- R5: up_ack stays high until the upstream request is seen low. It falls at the third rising edge after the request falls.
- R6: While the stage works, a high proc_done raises dn_req at the next edge. proc_done has no effect when the controller is idle.
- R7: dn_req falls at the third rising edge after dn_ack rises. busy stays high until dn_ack has also fallen.
- R8: busy clears at the third rising edge after dn_ack falls. A request that is still pending is then accepted at the following edge.
- R9: An upstream request pulse one cycle wide is still accepted. up_ack then rises for one cycle and falls, and the item completes normally.
- R10: A downstream acknowledge pulse one cycle wide still withdraws dn_req and returns the controller to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Upstream request (asynchronous) |
| up_ack | output | 1 | Upstream acknowledge |
| cap_en | output | 1 | One-cycle capture enable to the stage datapath |
| proc_done | input | 1 | Stage processing complete (synchronous) |
| dn_req | output | 1 | Downstream request |
| dn_ack | input | 1 | Downstream acknowledge (asynchronous) |
| busy | output | 1 | Stage holds an item |

## Verification
The hardest situations to reach are the ones where a partner breaks ordering. In one, the upstream request lasts only one cycle. In the other, the downstream acknowledge lasts one cycle and drops before dn_req has fallen. The bench drives those pulses on a falling edge and releases them one cycle later, so each one survives the synchroniser for exactly one cycle. A third situation is a request that arrives while busy, or while the previous acknowledge is still high. The bench reaches it by holding up_req high across a whole job, and by raising it again in the middle of a job.

// File: rtl/hs_stage_ctrl.sv
module hs_stage_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic up_req,
  output logic up_ack,
  output logic cap_en,
  input  logic proc_done,
  output logic dn_req,
  input  logic dn_ack,
  output logic busy
);

  typedef enum logic [1:0] {S_IDLE, S_WORK, S_DREQ, S_DREL} st_t;

  st_t state;
  logic [SYNC_STAGES-1:0] req_sh, ack_sh;
  logic req_s, ack_s, accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_sh <= '0;
      ack_sh <= '0;
    end else begin
      req_sh <= {req_sh[SYNC_STAGES-2:0], up_req};
      ack_sh <= {ack_sh[SYNC_STAGES-2:0], dn_ack};
    end
  end

  assign req_s  = req_sh[SYNC_STAGES-1];
  assign ack_s  = ack_sh[SYNC_STAGES-1];
  assign accept = (state == S_IDLE) && req_s && !up_ack;
  assign busy   = (state != S_IDLE);
  assign dn_req = (state == S_DREQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      up_ack <= 1'b0;
      cap_en <= 1'b0;
    end else begin
      cap_en <= accept;
      if (accept) up_ack <= 1'b1;
      else if (!req_s) up_ack <= 1'b0;
      case (state)
        S_IDLE: if (accept) state <= S_WORK;
        S_WORK: if (proc_done) state <= S_DREQ;
        S_DREQ: if (ack_s) state <= S_DREL;
        S_DREL: if (!ack_s) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r4_cap_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> !cap_en);

  a_r3_accept_signals: assert property (@(posedge clk) disable iff (rst)
    cap_en |-> (up_ack && busy));

  a_r2_accept_from_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(!up_ack));

  a_r5_ack_held: assert property (@(posedge clk) disable iff (rst)
    (up_ack && req_s) |=> up_ack);

  a_r6_req_after_done: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_req) |-> $past(proc_done));

  a_r7_busy_covers_req: assert property (@(posedge clk) disable iff (rst)
    $fell(dn_req) |-> busy);

  a_r8_busy_clear_after_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (!ack_s && !dn_req));

endmodule

// File: tb/hs_stage_ctrl_test.sv
module hs_stage_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_req = 1'b0, proc_done = 1'b0, dn_ack = 1'b0;
  logic up_ack, cap_en, dn_req, busy;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hs_stage_ctrl uut (
    .clk(clk), .rst(rst), .up_req(up_req), .up_ack(up_ack), .cap_en(cap_en),
    .proc_done(proc_done), .dn_req(dn_req), .dn_ack(dn_ack), .busy(busy)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic finish_job;
    proc_done = 1'b1; step(1); proc_done = 1'b0;
    dn_ack = 1'b1; step(4);
    dn_ack = 1'b0; step(4);
    chk("R8", "busy after job", busy, 1'b0);
  endtask

  task automatic t_reset;
    step(3);
    chk("R1", "busy in reset", busy, 1'b0);
    chk("R1", "up_ack in reset", up_ack, 1'b0);
    chk("R1", "dn_req in reset", dn_req, 1'b0);
    chk("R1", "cap_en in reset", cap_en, 1'b0);
    rst = 1'b0; step(1);
    chk("R1", "busy after reset", busy, 1'b0);
    chk("R1", "dn_req after reset", dn_req, 1'b0);
  endtask

  task automatic t_idle_done;
    proc_done = 1'b1; step(1); proc_done = 1'b0;
    chk("R6", "dn_req on idle done", dn_req, 1'b0);
    chk("R6", "busy on idle done", busy, 1'b0);
  endtask

  task automatic t_basic;
    up_req = 1'b1; step(2);
    chk("R3", "up_ack before accept", up_ack, 1'b0);
    step(1);
    chk("R3", "up_ack at accept", up_ack, 1'b1);
    chk("R3", "busy at accept", busy, 1'b1);
    chk("R4", "cap_en at accept", cap_en, 1'b1);
    step(1);
    chk("R4", "cap_en after one cycle", cap_en, 1'b0);
    up_req = 1'b0; step(2);
    chk("R5", "up_ack still held", up_ack, 1'b1);
    step(1);
    chk("R5", "up_ack released", up_ack, 1'b0);
    proc_done = 1'b1; step(1); proc_done = 1'b0;
    chk("R6", "dn_req after done", dn_req, 1'b1);
    dn_ack = 1'b1; step(2);
    chk("R7", "dn_req still high", dn_req, 1'b1);
    step(1);
    chk("R7", "dn_req withdrawn", dn_req, 1'b0);
    chk("R7", "busy while ack high", busy, 1'b1);
    dn_ack = 1'b0; step(2);
    chk("R8", "busy before ack low seen", busy, 1'b1);
    step(1);
    chk("R8", "busy cleared", busy, 1'b0);
  endtask

  task automatic t_hold_req;
    up_req = 1'b1; step(3);
    chk("R3", "hold: accepted", busy, 1'b1);
    finish_job();
    step(3);
    chk("R2", "hold: no re-accept busy", busy, 1'b0);
    chk("R2", "hold: ack still high", up_ack, 1'b1);
    chk("R2", "hold: no cap_en", cap_en, 1'b0);
    up_req = 1'b0; step(3);
    chk("R5", "hold: ack falls", up_ack, 1'b0);
    up_req = 1'b1; step(3);
    chk("R8", "hold: re-accept", up_ack, 1'b1);
    chk("R8", "hold: re-accept busy", busy, 1'b1);
    up_req = 1'b0; step(3);
    finish_job();
  endtask

  task automatic t_req_while_busy;
    up_req = 1'b1; step(3); up_req = 1'b0; step(3);
    up_req = 1'b1; step(5);
    chk("R2", "busy: ack stays low", up_ack, 1'b0);
    chk("R2", "busy: no cap_en", cap_en, 1'b0);
    proc_done = 1'b1; step(1); proc_done = 1'b0;
    dn_ack = 1'b1; step(4);
    dn_ack = 1'b0; step(3);
    chk("R8", "busy: idle edge", busy, 1'b0);
    chk("R8", "busy: ack low at idle", up_ack, 1'b0);
    step(1);
    chk("R8", "busy: pending accepted", up_ack, 1'b1);
    chk("R8", "busy: pending cap_en", cap_en, 1'b1);
    up_req = 1'b0; step(3);
    finish_job();
  endtask

  task automatic t_short_up;
    up_req = 1'b1; step(1); up_req = 1'b0; step(2);
    chk("R9", "short req: ack rises", up_ack, 1'b1);
    chk("R9", "short req: cap_en", cap_en, 1'b1);
    step(1);
    chk("R9", "short req: ack falls", up_ack, 1'b0);
    chk("R9", "short req: busy", busy, 1'b1);
    finish_job();
  endtask

  task automatic t_short_dn;
    up_req = 1'b1; step(3); up_req = 1'b0; step(3);
    proc_done = 1'b1; step(1); proc_done = 1'b0;
    chk("R10", "short ack: dn_req up", dn_req, 1'b1);
    dn_ack = 1'b1; step(1); dn_ack = 1'b0; step(1);
    chk("R10", "short ack: dn_req held", dn_req, 1'b1);
    step(1);
    chk("R10", "short ack: dn_req down", dn_req, 1'b0);
    step(1);
    chk("R10", "short ack: idle", busy, 1'b0);
  endtask

  initial begin
    t_reset();
    t_idle_done();
    t_basic();
    t_hold_req();
    t_req_while_busy();
    t_short_up();
    t_short_dn();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #160000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule